// File: doc/BRIEF.md
# Parallel Bus Request/Grant Sequencer

This block claims a shared parallel data bus from a host subsystem on behalf of an internal transfer engine. When the engine asks for a burst, the block drives an active-low request line and waits for the host's active-low grant. Once the grant arrives, it drives an active-low acknowledge and runs a train of fixed-length bus cycles. Each cycle has a one-clock chip-select strobe in its middle clock, and a direction output selects read or write. If the grant does not arrive within a parameterised number of clocks, the block drops the request. It then raises a sticky handshake-failure flag, which clears only when a later grant is seen or on reset.

The bus width is chosen per burst with a select input: 0 selects a 16-bit bus and 1 selects an 8-bit bus. On an 8-bit bus every word is carried as two byte cycles, low byte first, all under one grant. An address-float input decides whether the address, strobe and direction pins are driven all the time or only while acknowledge is active. The block reports this through a pin-driver enable.

States:
- `ST_IDLE`: waiting for work.
- `ST_REQ`: request asserted, grant timer running.
- `ST_SETUP`, `ST_STROBE`, `ST_HOLD`: the three clocks of one bus cycle.

Transitions:
- IDLE to REQ on a start pulse.
- REQ to SETUP when the grant is sampled low.
- REQ to IDLE when the timer expires.
- SETUP to STROBE to HOLD, unconditionally.
- HOLD to SETUP when more beats remain.
- HOLD to IDLE after the last beat.

Top module: `dma_bus_handshake`

## Requirements
- R1: After `xfer_start` is sampled high in idle, `req_n` is low from the next clock. It stays low until the burst ends or the grant timer expires.
- R2: A grant (`grant_n` = 0) sampled while requesting makes `ack_n` go low on the next clock. `ack_n` stays low through the last bus cycle. `req_n` and `ack_n` then return high together.
- R3: If `grant_n` stays high for `TIMEOUT` clocks of request, `req_n` returns high and `hsfail_n` goes low, and `ack_n` never asserts. A grant sampled in the last of those clocks is still accepted.
- R4: `hsfail_n` stays low until `grant_n` is sampled low or reset is applied.
- R5: Each bus cycle lasts exactly three clocks. `cs_n` is low only in the middle clock, and never while `ack_n` is high.
- R6: `rd_wr` is 1 during every bus cycle of a read burst (`xfer_read` = 1) and 0 at all other times.
- R7: `drv_en` is 1 whenever `addr_float` = 0. When `addr_float` = 1, `drv_en` is 1 only while `ack_n` is low.
- R8: With `bus_8bit` = 1, a burst of N words runs 2N bus cycles. `byte_hi` is 0 then 1 within each word, and `word_idx` counts 0 to N-1.
- R9: With `bus_8bit` = 0, a burst of N words (1 ≤ N) runs N bus cycles with `byte_hi` = 0 and `word_idx` counting 0 to N-1.
- R10: `xfer_start` is ignored while a burst or request is in progress. The burst length is not changed.
- R11: During and after reset, `req_n`, `ack_n`, `hsfail_n` and `cs_n` are 1, and `rd_wr` and `xfer_end` are 0.
- R12: `xfer_end` is high for exactly one clock: the final clock of the last bus cycle, or the last clock of a request that times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start-burst pulse from the transfer engine |
| xfer_read | input | 1 | 1: burst reads words from the host |
| xfer_len | input | LEN_W | Burst length in words (at least 1) |
| bus_8bit | input | 1 | Bus width select: 0 = 16-bit, 1 = 8-bit |
| addr_float | input | 1 | 1: pins float outside acknowledge |
| grant_n | input | 1 | Active-low bus grant from the host |
| req_n | output | 1 | Active-low bus request |
| ack_n | output | 1 | Active-low grant acknowledge |
| hsfail_n | output | 1 | Active-low sticky handshake failure |
| cs_n | output | 1 | Active-low mid-cycle strobe |
| rd_wr | output | 1 | Direction: 1 = read, 0 = write |
| drv_en | output | 1 | Enable for address/strobe/direction pin drivers |
| word_idx | output | LEN_W | Index of the current word in the burst |
| byte_hi | output | 1 | 1 when the current 8-bit cycle carries the high byte |
| xfer_end | output | 1 | One-clock end-of-burst or timeout pulse |

## Verification
The hardest situation to reach is the boundary of the grant window. A grant that first appears in the final clock before expiry must win over the timeout. One clock later, it must lose. The stimulus holds `grant_n` high for a counted number of clocks after the request first shows low, with a bench timeout of 8. It then drops the grant at exactly the seventh clock and, in a separate burst, never drops it. The sticky failure flag is then watched across idle clocks, and a following granted burst shows it clearing.

// File: rtl/dbh_pkg.sv
package dbh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } dbh_state_e;
endpackage

// File: rtl/dbh_grant_timer.sv
module dbh_grant_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT) + 1;
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    p_timer_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < TW'(TIMEOUT)));
endmodule

// File: rtl/dbh_fail_latch.sv
module dbh_fail_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_n <= 1'b1;
        end else if (clr) begin
            flag_n <= 1'b1;
        end else if (set) begin
            flag_n <= 1'b0;
        end
    end

    p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_n && !clr) |=> !flag_n);
endmodule

// File: rtl/dbh_beat_seq.sv
module dbh_beat_seq #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             mode8,
    input  logic             advance,
    output logic [LEN_W-1:0] word_idx,
    output logic             byte_hi,
    output logic             last
);
    localparam int BW = LEN_W + 1;

    logic [BW-1:0] beat;
    logic [BW-1:0] last_beat;
    logic          mode8_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat      <= '0;
            last_beat <= '0;
            mode8_q   <= 1'b0;
        end else if (load) begin
            beat      <= '0;
            mode8_q   <= mode8;
            last_beat <= mode8 ? (({1'b0, len} << 1) - 1'b1)
                               : ({1'b0, len} - 1'b1);
        end else if (advance) begin
            beat <= beat + 1'b1;
        end
    end

    assign last     = (beat == last_beat);
    assign byte_hi  = mode8_q & beat[0];
    assign word_idx = mode8_q ? beat[BW-1:1] : beat[LEN_W-1:0];

    p_beat_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (beat < last_beat));
endmodule

// File: rtl/dma_bus_handshake.sv
module dma_bus_handshake
    import dbh_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int LEN_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_read,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             bus_8bit,
    input  logic             addr_float,
    input  logic             grant_n,
    output logic             req_n,
    output logic             ack_n,
    output logic             hsfail_n,
    output logic             cs_n,
    output logic             rd_wr,
    output logic             drv_en,
    output logic [LEN_W-1:0] word_idx,
    output logic             byte_hi,
    output logic             xfer_end
);
    dbh_state_e state, state_nx;
    logic       rd_q;
    logic       expired;
    logic       last_beat;
    logic       timeout_hit;
    logic       in_xfer;

    // State register and captured direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rd_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && xfer_start) begin
                rd_q <= xfer_read;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (xfer_start) state_nx = ST_REQ;
            ST_REQ: begin
                if (!grant_n)     state_nx = ST_SETUP;
                else if (expired) state_nx = ST_IDLE;
            end
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: state_nx = ST_HOLD;
            ST_HOLD:   state_nx = last_beat ? ST_IDLE : ST_SETUP;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign timeout_hit = (state == ST_REQ) && grant_n && expired;

    // Output decode
    always_comb begin
        in_xfer  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        req_n    = (state == ST_IDLE);
        ack_n    = !in_xfer;
        cs_n     = (state != ST_STROBE);
        rd_wr    = in_xfer && rd_q;
        drv_en   = !addr_float || in_xfer;
        xfer_end = ((state == ST_HOLD) && last_beat) || timeout_hit;
    end

    dbh_grant_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_IDLE),
        .run     (state == ST_REQ),
        .expired (expired)
    );

    dbh_fail_latch u_fail (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (timeout_hit),
        .clr    (!grant_n),
        .flag_n (hsfail_n)
    );

    dbh_beat_seq #(.LEN_W(LEN_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state == ST_IDLE) && xfer_start),
        .len      (xfer_len),
        .mode8    (bus_8bit),
        .advance  ((state == ST_HOLD) && !last_beat),
        .word_idx (word_idx),
        .byte_hi  (byte_hi),
        .last     (last_beat)
    );

    p_ack_within_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !req_n);
    p_cs_in_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !ack_n);
    p_cs_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> cs_n);
    p_rw_rests_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> !rd_wr);
    p_end_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> !xfer_end);
endmodule

// File: tb/tb_dma_bus_handshake.sv
module tb_dma_bus_handshake;
    localparam int TIMEOUT = 8;
    localparam int LEN_W   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xfer_start = 1'b0;
    logic             xfer_read = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             bus_8bit = 1'b0;
    logic             addr_float = 1'b1;
    logic             grant_n = 1'b1;
    logic             req_n, ack_n, hsfail_n, cs_n, rd_wr, drv_en, byte_hi, xfer_end;
    logic [LEN_W-1:0] word_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_bus_handshake #(.TIMEOUT(TIMEOUT), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_read(xfer_read),
        .xfer_len(xfer_len), .bus_8bit(bus_8bit), .addr_float(addr_float),
        .grant_n(grant_n), .req_n(req_n), .ack_n(ack_n), .hsfail_n(hsfail_n),
        .cs_n(cs_n), .rd_wr(rd_wr), .drv_en(drv_en), .word_idx(word_idx),
        .byte_hi(byte_hi), .xfer_end(xfer_end)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One granted burst; gdelay = clocks of request before grant
    task automatic run_burst(input int len, input bit rd, input bit m8,
                             input int gdelay, input bit poke);
        int beats;
        beats = m8 ? 2 * len : len;
        bus_8bit   = m8;
        xfer_read  = rd;
        xfer_len   = LEN_W'(len);
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
        chk("R1 req_n low after start", int'(req_n), 0);
        chk("R2 ack_n high before grant", int'(ack_n), 1);
        for (int d = 0; d < gdelay; d++) begin
            tick();
            chk("R1 req_n held while waiting", int'(req_n), 0);
            chk("R3 no ack before grant", int'(ack_n), 1);
        end
        grant_n = 1'b0;
        tick();
        chk("R4 hsfail_n cleared by grant", int'(hsfail_n), 1);
        for (int b = 0; b < beats; b++) begin
            chk("R2 ack_n low in cycle", int'(ack_n), 0);
            chk("R5 cs_n high in setup", int'(cs_n), 1);
            chk("R6 rd_wr in cycle", int'(rd_wr), int'(rd));
            chk("R7 drv_en during ack", int'(drv_en), 1);
            chk(m8 ? "R8 word_idx" : "R9 word_idx", int'(word_idx), m8 ? b / 2 : b);
            chk(m8 ? "R8 byte_hi" : "R9 byte_hi", int'(byte_hi), m8 ? b % 2 : 0);
            if (poke && b == 0) begin
                xfer_start = 1'b1;
                xfer_len   = LEN_W'(len + 3);
            end
            tick();
            xfer_start = 1'b0;
            xfer_len   = LEN_W'(len);
            chk("R5 cs_n low in middle", int'(cs_n), 0);
            tick();
            chk("R5 cs_n high in hold", int'(cs_n), 1);
            chk("R12 xfer_end on last hold only", int'(xfer_end), int'(b == beats - 1));
            tick();
        end
        chk(poke ? "R10 burst length unchanged req_n" : "R2 req_n released", int'(req_n), 1);
        chk("R2 ack_n released", int'(ack_n), 1);
        chk("R6 rd_wr back to write", int'(rd_wr), 0);
        chk("R12 xfer_end cleared", int'(xfer_end), 0);
        grant_n = 1'b1;
        tick();
    endtask

    task automatic test_reset();
        chk("R11 req_n reset", int'(req_n), 1);
        chk("R11 ack_n reset", int'(ack_n), 1);
        chk("R11 hsfail_n reset", int'(hsfail_n), 1);
        chk("R11 cs_n reset", int'(cs_n), 1);
        chk("R11 rd_wr reset", int'(rd_wr), 0);
        chk("R11 xfer_end reset", int'(xfer_end), 0);
    endtask

    task automatic test_timeout();
        xfer_len   = 8'd2;
        xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
        for (int c = 1; c < TIMEOUT; c++) begin
            chk("R1 req_n low before expiry", int'(req_n), 0);
            chk("R12 no early end", int'(xfer_end), 0);
            tick();
        end
        chk("R12 xfer_end on timeout clock", int'(xfer_end), 1);
        chk("R3 hsfail_n not yet set", int'(hsfail_n), 1);
        tick();
        chk("R3 req_n released on timeout", int'(req_n), 1);
        chk("R3 hsfail_n low on timeout", int'(hsfail_n), 0);
        chk("R3 no ack on timeout", int'(ack_n), 1);
        for (int c = 0; c < 5; c++) begin
            tick();
            chk("R4 hsfail_n latched", int'(hsfail_n), 0);
        end
    endtask

    task automatic test_drv();
        addr_float = 1'b1;
        tick();
        chk("R7 drv_en off when floating idle", int'(drv_en), 0);
        addr_float = 1'b0;
        tick();
        chk("R7 drv_en on when not floating", int'(drv_en), 1);
        addr_float = 1'b1;
    endtask

    initial begin
        repeat (3) tick();
        test_reset();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_drv();
        run_burst(3, 1'b0, 1'b0, 0, 1'b0);
        run_burst(2, 1'b1, 1'b1, 2, 1'b0);
        run_burst(1, 1'b1, 1'b0, TIMEOUT - 1, 1'b0);   // R3 grant in last clock
        test_timeout();
        run_burst(2, 1'b0, 1'b0, 1, 1'b1);             // R4 clear, R10 poke
        addr_float = 1'b0;
        run_burst(1, 1'b0, 1'b1, 0, 1'b0);
        chk("R7 drv_en idle when not floating", int'(drv_en), 1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule